// File: doc/BRIEF.md
# Banked UART Control Register File

This block holds the software-visible control state of a 16550-style UART that has extended features. It sits behind a plain word-indexed bus (index, write data, write enable, read enable, combinational read data). The byte last written to the line control register selects the current access bank: operational, configuration A or configuration B. The same index then reaches a different physical register depending on the bank. Writes to some fields are accepted only while a gating condition holds.

The block drives the divisor, the line format byte, the FIFO enable, flush and trigger settings, the trigger granularity bits, the operating mode, the interrupt enables, and the modem and feature control bytes straight into the rest of the UART. In the operational bank, index 0 becomes the data port. A write there raises a transmit push strobe that carries the byte. A read there returns the receive byte and raises a pop strobe. The serial shifters, the FIFOs and the baud generator live outside this block.

Top module: `uart_bank_regfile`

## Requirements
- R1: The bank is operational when line control bit 7 is 0, configuration B when line control equals 0xBF, and configuration A for any other value with bit 7 set. Index 3 reads and writes the line control byte in every bank.
- R2: In configuration A and B, index 0 is the divisor low byte and index 1 the divisor high byte. In the operational bank, index 1 is the interrupt enable byte. A write to index 0 asserts `tx_push` with `tx_byte` equal to the write data in the same cycle. A read of index 0 with `rd_en` returns `rx_byte` and asserts `rx_pop` in the same cycle.
- R3: Index 2 reads and writes the 8-bit feature control byte only in configuration B. Bit 4 of that byte is the enhanced-control gate, and writes to index 2 in the other banks leave it unchanged.
- R4: An interrupt enable write always updates bits 3:0. It updates bits 7:4 only while feature bit 4 is 1, and otherwise those bits keep their value.
- R5: Index 4 is the modem control byte in the operational bank and in configuration A. Its bit 6 (table submode) takes a write only while feature bit 4 is 1. In configuration B, index 4 reads 0 and ignores writes.
- R6: A write to index 2 outside configuration B loads the write-only FIFO control fields: bit 0 enable, bit 3 DMA select, bits 5:4 transmit trigger, bits 7:6 receive trigger. Bits 1 and 2 produce one-cycle `rx_flush` and `tx_flush` pulses in the cycle after the write.
- R7: A read of index 2 outside configuration B returns {fifo enable, fifo enable, 2'b00, `irq_cause`, not `irq_pending`}, so bit 0 is 1 when no interrupt is pending.
- R8: Index 8 holds the 3-bit operating mode in every bank and reads back with bits 7:3 zero. Its reset value is 7 (disabled). The other codes used are 0 (16x) and 3 (13x).
- R9: A divisor byte write takes effect only while the mode is 7 and interrupt enable bit 4 (sleep) is 0. Otherwise the divisor keeps its value.
- R10: Index 16 holds the supplementary byte in every bank. Bit 7 drives `rx_gran_one`, bit 6 drives `tx_gran_one` and bit 3 drives `tx_empty_ctl`.
- R11: After reset, the line control, interrupt enable, feature, modem, supplementary and divisor values are 0, the FIFO fields are 0, and the mode is 7.
- R12: Every other index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | IDX_W | Register index |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (used for the data port pop) |
| rd_data | output | 8 | Combinational read data for `reg_idx` |
| rx_byte | input | 8 | Receive byte offered by the receive FIFO |
| irq_pending | input | 1 | An interrupt is pending |
| irq_cause | input | 3 | Code of the pending interrupt source |
| tx_byte | output | 8 | Byte to push into the transmit FIFO |
| tx_push | output | 1 | Transmit push strobe |
| rx_pop | output | 1 | Receive pop strobe |
| baud_div | output | 16 | Baud divisor |
| line_ctl | output | 8 | Line control byte (format and bank select) |
| int_enable | output | 8 | Interrupt enable byte |
| modem_ctl | output | 8 | Modem control byte |
| feature_ctl | output | 8 | Feature control byte (flow control, enhanced gate) |
| fifo_enable | output | 1 | FIFOs enabled |
| fifo_dma | output | 1 | FIFO DMA select |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |
| rx_trig_sel | output | 2 | Receive trigger select |
| tx_trig_sel | output | 2 | Transmit trigger select |
| rx_gran_one | output | 1 | Receive trigger granularity of one |
| tx_gran_one | output | 1 | Transmit trigger granularity of one |
| tx_empty_ctl | output | 1 | Transmit-empty control |
| op_mode | output | 3 | Operating mode code |

## Verification
The bench builds the block with the default IDX_W of 5. That puts index 16 in range together with unmapped indexes such as 5 and 31, so the decode of every bank, including its default, is exercised. Random writes use a bias toward the three bank-selecting line control values. This drives the gating rules through all combinations of the enhanced gate, the sleep bit and the mode code, and a bench model predicts each read-back.

// File: rtl/uart_bank_pkg.sv
// Shared definitions for the banked UART register file: bank encoding,
// register indexes, special values and gating bit positions.
package uart_bank_pkg;
    typedef enum logic [1:0] {
        BANK_OPER  = 2'd0,
        BANK_CFG_A = 2'd1,
        BANK_CFG_B = 2'd2
    } bank_e;

    localparam int IDX_DATA  = 0;
    localparam int IDX_INTEN = 1;
    localparam int IDX_FIFO  = 2;
    localparam int IDX_LINE  = 3;
    localparam int IDX_MODEM = 4;
    localparam int IDX_MODE  = 8;
    localparam int IDX_SUPP  = 16;

    localparam logic [7:0] LINE_CFG_B = 8'hBF;
    localparam logic [2:0] MODE_UART16 = 3'd0;
    localparam logic [2:0] MODE_UART13 = 3'd3;
    localparam logic [2:0] MODE_OFF    = 3'd7;

    localparam int GATE_BIT    = 4;  // enhanced-control gate in feature byte
    localparam int SLEEP_BIT   = 4;  // sleep bit in interrupt enable byte
    localparam int SUBMODE_BIT = 6;  // table submode bit in modem byte
endpackage

// File: rtl/uart_bank_decode.sv
// Bank decode: derives the access bank from the line control byte and turns
// the bus strobes into per-register write enables and data-port strobes.
// Assumes the line control byte is the registered value (bank changes take
// effect on the cycle after the line control write).
module uart_bank_decode
    import uart_bank_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [7:0]       line_q,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             wr_en,
    input  logic             rd_en,
    output bank_e            bank,
    output logic             we_div_lo,
    output logic             we_div_hi,
    output logic             we_inten,
    output logic             we_fifo,
    output logic             we_feat,
    output logic             we_line,
    output logic             we_modem,
    output logic             we_mode,
    output logic             we_supp,
    output logic             tx_push,
    output logic             rx_pop
);
    logic hit_data, hit_inten, hit_fifo, hit_line, hit_modem, hit_mode, hit_supp;
    logic is_oper, is_b;

    // Pick the bank from the line control byte.
    always_comb begin
        if (!line_q[7])               bank = BANK_OPER;
        else if (line_q == LINE_CFG_B) bank = BANK_CFG_B;
        else                          bank = BANK_CFG_A;
    end

    // Match the index against each register slot.
    always_comb begin
        hit_data  = (reg_idx == IDX_W'(IDX_DATA));
        hit_inten = (reg_idx == IDX_W'(IDX_INTEN));
        hit_fifo  = (reg_idx == IDX_W'(IDX_FIFO));
        hit_line  = (reg_idx == IDX_W'(IDX_LINE));
        hit_modem = (reg_idx == IDX_W'(IDX_MODEM));
        hit_mode  = (reg_idx == IDX_W'(IDX_MODE));
        hit_supp  = (reg_idx == IDX_W'(IDX_SUPP));
        is_oper   = (bank == BANK_OPER);
        is_b      = (bank == BANK_CFG_B);
    end

    // Form the write enables per bank.
    always_comb begin
        we_div_lo = wr_en && hit_data  && !is_oper;
        we_div_hi = wr_en && hit_inten && !is_oper;
        we_inten  = wr_en && hit_inten && is_oper;
        we_fifo   = wr_en && hit_fifo  && !is_b;
        we_feat   = wr_en && hit_fifo  && is_b;
        we_line   = wr_en && hit_line;
        we_modem  = wr_en && hit_modem && !is_b;
        we_mode   = wr_en && hit_mode;
        we_supp   = wr_en && hit_supp;
        tx_push   = wr_en && hit_data  && is_oper;
        rx_pop    = rd_en && hit_data  && is_oper;
    end
endmodule

// File: rtl/uart_bank_divisor.sv
// Divisor holder: two byte registers that accept writes only while the UART
// mode is disabled and the sleep bit is clear. Assumes the write enables
// already carry the bank decode.
module uart_bank_divisor
    import uart_bank_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [7:0]       wdata,
    input  logic [2:0]       mode_q,
    input  logic             sleep,
    output logic [DIV_W-1:0] div_q
);
    localparam int HI_W = DIV_W - 8;

    logic unlock;

    // Divisor may change only with the UART disabled and awake.
    always_comb unlock = (mode_q == MODE_OFF) && !sleep;

    // Load the low and high divisor bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (unlock) begin
            if (we_lo) div_q[7:0]       <= wdata;
            if (we_hi) div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
        end
    end

    // R9
    div_lo_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !unlock) |=> $stable(div_q[7:0]));

    // R9
    div_hi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !unlock) |=> $stable(div_q[DIV_W-1:8]));
endmodule

// File: rtl/uart_bank_ctrl_regs.sv
// Control registers: line control, interrupt enable, feature, modem, mode,
// supplementary and the write-only FIFO control fields with flush pulses.
// Gated fields follow the enhanced-control bit of the feature byte.
module uart_bank_ctrl_regs
    import uart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    input  logic       we_inten,
    input  logic       we_fifo,
    input  logic       we_feat,
    input  logic       we_line,
    input  logic       we_modem,
    input  logic       we_mode,
    input  logic       we_supp,
    output logic [7:0] line_q,
    output logic [7:0] inten_q,
    output logic [7:0] feat_q,
    output logic [7:0] modem_q,
    output logic [2:0] mode_q,
    output logic [7:0] supp_q,
    output logic       fifo_en,
    output logic       fifo_dma,
    output logic [1:0] rx_trig,
    output logic [1:0] tx_trig,
    output logic       rx_flush,
    output logic       tx_flush
);
    logic gate;

    // Enhanced-control gate from the feature byte.
    always_comb gate = feat_q[GATE_BIT];

    // Line control byte, also the bank selector.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_q <= '0;
        else if (we_line) line_q <= wdata;
    end

    // Interrupt enables; the upper nibble obeys the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inten_q <= '0;
        end else if (we_inten) begin
            inten_q[3:0] <= wdata[3:0];
            if (gate) inten_q[7:4] <= wdata[7:4];
        end
    end

    // Feature control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       feat_q <= '0;
        else if (we_feat) feat_q <= wdata;
    end

    // Modem control; the submode bit obeys the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modem_q <= '0;
        end else if (we_modem) begin
            modem_q[7]   <= wdata[7];
            modem_q[5:0] <= wdata[5:0];
            if (gate) modem_q[SUBMODE_BIT] <= wdata[SUBMODE_BIT];
        end
    end

    // Operating mode, disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_OFF;
        else if (we_mode) mode_q <= wdata[2:0];
    end

    // Supplementary control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       supp_q <= '0;
        else if (we_supp) supp_q <= wdata;
    end

    // Write-only FIFO fields and self-clearing flush pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            fifo_dma <= 1'b0;
            rx_trig  <= '0;
            tx_trig  <= '0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= we_fifo && wdata[1];
            tx_flush <= we_fifo && wdata[2];
            if (we_fifo) begin
                fifo_en  <= wdata[0];
                fifo_dma <= wdata[3];
                tx_trig  <= wdata[5:4];
                rx_trig  <= wdata[7:6];
            end
        end
    end

    // R4
    inten_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_inten && !gate) |=> $stable(inten_q[7:4]));

    // R5
    modem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_modem && !gate) |=> $stable(modem_q[SUBMODE_BIT]));

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !we_fifo) |=> !rx_flush);
endmodule

// File: rtl/uart_bank_regfile.sv
// Top of the banked UART register file: ties the decode, the divisor and
// the control registers together and forms the combinational read data.
// Assumes a single-master bus with at most one access per cycle.
module uart_bank_regfile
    import uart_bank_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic [7:0]       rx_byte,
    input  logic             irq_pending,
    input  logic [2:0]       irq_cause,
    output logic [7:0]       tx_byte,
    output logic             tx_push,
    output logic             rx_pop,
    output logic [DIV_W-1:0] baud_div,
    output logic [7:0]       line_ctl,
    output logic [7:0]       int_enable,
    output logic [7:0]       modem_ctl,
    output logic [7:0]       feature_ctl,
    output logic             fifo_enable,
    output logic             fifo_dma,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic [1:0]       rx_trig_sel,
    output logic [1:0]       tx_trig_sel,
    output logic             rx_gran_one,
    output logic             tx_gran_one,
    output logic             tx_empty_ctl,
    output logic [2:0]       op_mode
);
    bank_e      bank;
    logic       we_div_lo, we_div_hi, we_inten, we_fifo, we_feat;
    logic       we_line, we_modem, we_mode, we_supp;
    logic [7:0] supp_q;
    logic [7:0] ident;

    uart_bank_decode #(.IDX_W(IDX_W)) i_decode (
        .line_q    (line_ctl),
        .reg_idx   (reg_idx),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .bank      (bank),
        .we_div_lo (we_div_lo),
        .we_div_hi (we_div_hi),
        .we_inten  (we_inten),
        .we_fifo   (we_fifo),
        .we_feat   (we_feat),
        .we_line   (we_line),
        .we_modem  (we_modem),
        .we_mode   (we_mode),
        .we_supp   (we_supp),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop)
    );

    uart_bank_divisor #(.DIV_W(DIV_W)) i_divisor (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_lo  (we_div_lo),
        .we_hi  (we_div_hi),
        .wdata  (wr_data),
        .mode_q (op_mode),
        .sleep  (int_enable[SLEEP_BIT]),
        .div_q  (baud_div)
    );

    uart_bank_ctrl_regs i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wr_data),
        .we_inten (we_inten),
        .we_fifo  (we_fifo),
        .we_feat  (we_feat),
        .we_line  (we_line),
        .we_modem (we_modem),
        .we_mode  (we_mode),
        .we_supp  (we_supp),
        .line_q   (line_ctl),
        .inten_q  (int_enable),
        .feat_q   (feature_ctl),
        .modem_q  (modem_ctl),
        .mode_q   (op_mode),
        .supp_q   (supp_q),
        .fifo_en  (fifo_enable),
        .fifo_dma (fifo_dma),
        .rx_trig  (rx_trig_sel),
        .tx_trig  (tx_trig_sel),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    // Pass the transmit byte and split out the supplementary bits.
    always_comb begin
        tx_byte      = wr_data;
        rx_gran_one  = supp_q[7];
        tx_gran_one  = supp_q[6];
        tx_empty_ctl = supp_q[3];
        ident        = {fifo_enable, fifo_enable, 2'b00, irq_cause, !irq_pending};
    end

    // Read data multiplexer across banks.
    always_comb begin
        rd_data = '0;
        case (reg_idx)
            IDX_W'(IDX_DATA):  rd_data = (bank == BANK_OPER) ? rx_byte : baud_div[7:0];
            IDX_W'(IDX_INTEN): rd_data = (bank == BANK_OPER) ? int_enable
                                                             : 8'(baud_div[DIV_W-1:8]);
            IDX_W'(IDX_FIFO):  rd_data = (bank == BANK_CFG_B) ? feature_ctl : ident;
            IDX_W'(IDX_LINE):  rd_data = line_ctl;
            IDX_W'(IDX_MODEM): rd_data = (bank == BANK_CFG_B) ? 8'h00 : modem_ctl;
            IDX_W'(IDX_MODE):  rd_data = {5'b0, op_mode};
            IDX_W'(IDX_SUPP):  rd_data = supp_q;
            default:           rd_data = '0;
        endcase
    end

    // R1
    line_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(IDX_LINE)) |-> (rd_data == line_ctl));

    // R3
    feat_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(feature_ctl) |-> ($past(wr_en) && $past(reg_idx) == IDX_W'(IDX_FIFO)
                                   && $past(line_ctl) == LINE_CFG_B));

    // R8
    mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(IDX_MODE)) |-> (rd_data[7:3] == 5'b0));
endmodule

// File: tb/test_uart_bank_regfile.sv
module test_uart_bank_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 5;
    localparam int WATCHDOG = 50000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [7:0]       wr_data = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic [7:0]       rx_byte = 8'h3C;
    logic             irq_pending = 1'b0;
    logic [2:0]       irq_cause = '0;
    logic [7:0]       tx_byte;
    logic             tx_push, rx_pop;
    logic [15:0]      baud_div;
    logic [7:0]       line_ctl, int_enable, modem_ctl, feature_ctl;
    logic             fifo_enable, fifo_dma, rx_flush, tx_flush;
    logic [1:0]       rx_trig_sel, tx_trig_sel;
    logic             rx_gran_one, tx_gran_one, tx_empty_ctl;
    logic [2:0]       op_mode;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // reference model state
    logic [7:0]  m_line = 0, m_inten = 0, m_feat = 0, m_modem = 0, m_supp = 0;
    logic [2:0]  m_mode = 3'd7;
    logic [15:0] m_div = 0;
    logic        m_fen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_bank_regfile #(.IDX_W(IDX_W)) i_uart_bank_regfile (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rx_byte(rx_byte),
        .irq_pending(irq_pending), .irq_cause(irq_cause), .tx_byte(tx_byte),
        .tx_push(tx_push), .rx_pop(rx_pop), .baud_div(baud_div),
        .line_ctl(line_ctl), .int_enable(int_enable), .modem_ctl(modem_ctl),
        .feature_ctl(feature_ctl), .fifo_enable(fifo_enable), .fifo_dma(fifo_dma),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_trig_sel(rx_trig_sel),
        .tx_trig_sel(tx_trig_sel), .rx_gran_one(rx_gran_one),
        .tx_gran_one(tx_gran_one), .tx_empty_ctl(tx_empty_ctl), .op_mode(op_mode)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 = operational, 1 = configuration A, 2 = configuration B
    function automatic int bank_of(input logic [7:0] l);
        if (!l[7]) return 0;
        if (l == 8'hBF) return 2;
        return 1;
    endfunction

    function automatic logic [7:0] exp_rd(input int idx);
        int b = bank_of(m_line);
        case (idx)
            0:  return (b == 0) ? rx_byte : m_div[7:0];
            1:  return (b == 0) ? m_inten : m_div[15:8];
            2:  return (b == 2) ? m_feat
                               : {m_fen, m_fen, 2'b00, irq_cause, !irq_pending};
            3:  return m_line;
            4:  return (b == 2) ? 8'h00 : m_modem;
            8:  return {5'b0, m_mode};
            16: return m_supp;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int idx);
        case (idx)
            0, 1: return "R2";
            2:  return (bank_of(m_line) == 2) ? "R3" : "R7";
            3:  return "R1";
            4:  return "R5";
            8:  return "R8";
            16: return "R10";
            default: return "R12";
        endcase
    endfunction

    // Update the model, then perform the bus write (returns at a falling edge).
    task automatic do_wr(input int idx, input logic [7:0] d);
        int b = bank_of(m_line);
        bit unlock = (m_mode == 3'd7) && !m_inten[4];
        case (idx)
            0: if (b != 0 && unlock) m_div[7:0] = d;
            1: if (b == 0) m_inten = {m_feat[4] ? d[7:4] : m_inten[7:4], d[3:0]};
               else if (unlock) m_div[15:8] = d;
            2: if (b == 2) m_feat = d; else m_fen = d[0];
            3: m_line = d;
            4: if (b != 2) m_modem = {d[7], m_feat[4] ? d[6] : m_modem[6], d[5:0]};
            8: m_mode = d[2:0];
            16: m_supp = d;
            default: ;
        endcase
        reg_idx = IDX_W'(idx);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_rd_chk(input int idx, input string tag);
        reg_idx = IDX_W'(idx);
        #1;
        chk(tag, {8'h00, rd_data}, {8'h00, exp_rd(idx)});
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int idx_list[8] = '{0, 1, 2, 3, 4, 5, 8, 16};
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset values
        do_rd_chk(1, "R11 inten");
        do_rd_chk(3, "R11 line");
        do_rd_chk(4, "R11 modem");
        do_rd_chk(8, "R11 mode");
        do_rd_chk(16, "R11 supp");
        chk("R11 divisor", baud_div, 16'h0000);
        chk("R11 feature", {8'h00, feature_ctl}, 16'h0000);
        chk("R11 fifo", {14'h0, fifo_enable, rx_flush}, 16'h0000);

        // R1/R2/R9: config A divisor access
        do_wr(3, 8'h83);
        do_rd_chk(3, "R1 line in A");
        do_wr(0, 8'h34);
        do_wr(1, 8'h12);
        chk("R9 divisor load", baud_div, 16'h1234);
        do_rd_chk(0, "R2 div lo");
        do_rd_chk(1, "R2 div hi");

        // R3: feature byte in B
        do_wr(3, 8'hBF);
        do_rd_chk(3, "R1 line in B");
        do_wr(2, 8'h10);
        do_rd_chk(2, "R3 feature");
        do_wr(4, 8'hFF);
        do_rd_chk(4, "R5 modem hidden in B");

        // R4: upper enables writable with gate set
        do_wr(3, 8'h03);
        do_wr(1, 8'hF5);
        chk("R4 gate on", {8'h00, int_enable}, 16'h00F5);
        do_wr(3, 8'hBF);
        do_wr(2, 8'h00);
        do_wr(3, 8'h03);
        do_wr(1, 8'h0A);
        chk("R4 gate off", {8'h00, int_enable}, 16'h00FA);

        // R9: sleep bit blocks divisor
        do_wr(3, 8'h80);
        do_wr(0, 8'h99);
        chk("R9 sleep lock", baud_div, 16'h1234);

        // R5: submode bit ignored without gate
        do_wr(4, 8'h5B);
        chk("R5 submode gate", {8'h00, modem_ctl}, 16'h001B);

        // R8: mode code, divisor lock by mode
        do_wr(8, 8'hF8);
        chk("R8 mode 16x", {13'h0, op_mode}, 16'h0000);
        do_rd_chk(8, "R8 mode read");

        // R6/R7: FIFO control and identification
        do_wr(3, 8'h00);
        do_wr(2, 8'h6F);
        chk("R6 flush pulses", {14'h0, rx_flush, tx_flush}, 16'h0003);
        chk("R6 fields", {10'h0, rx_trig_sel, tx_trig_sel, fifo_dma, fifo_enable},
            16'h001B);
        @(negedge clk);
        chk("R6 flush clears", {14'h0, rx_flush, tx_flush}, 16'h0000);
        irq_pending = 1'b1;
        irq_cause   = 3'b010;
        do_rd_chk(2, "R7 ident pending");
        irq_pending = 1'b0;
        do_rd_chk(2, "R7 ident idle");

        // R2: data port strobes
        reg_idx = IDX_W'(0);
        wr_data = 8'hA5;
        wr_en   = 1'b1;
        #1;
        chk("R2 tx push", {7'h0, tx_push, tx_byte}, 16'h01A5);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b1;
        #1;
        chk("R2 rx pop", {7'h0, rx_pop, rd_data}, {8'h01, rx_byte});
        rd_en = 1'b0;

        // R10: supplementary bits
        do_wr(16, 8'hC8);
        chk("R10 supp bits", {13'h0, rx_gran_one, tx_gran_one, tx_empty_ctl}, 16'h0007);

        // R12: unmapped index
        do_wr(5, 8'hEE);
        do_rd_chk(5, "R12 unmapped");
        do_rd_chk(31, "R12 unmapped top");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            int idx = idx_list[$urandom_range(0, 7)];
            logic [7:0] d = 8'($urandom);
            if (idx == 3) begin
                case ($urandom_range(0, 3))
                    0: d = 8'h00;
                    1: d = 8'h80;
                    2: d = 8'hBF;
                    default: ;
                endcase
            end
            if (idx == 8 && $urandom_range(0, 1) == 1) d = 8'h07;
            rx_byte     = 8'($urandom);
            irq_pending = 1'($urandom);
            irq_cause   = 3'($urandom);
            do_wr(idx, d);
            begin
                int ri = idx_list[$urandom_range(0, 7)];
                do_rd_chk(ri, tag_of(ri));
            end
            if (n % 20 == 0) begin
                chk("R9 divisor model", baud_div, m_div);
                chk("R4 inten model", {8'h00, int_enable}, {8'h00, m_inten});
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule